// File: doc/BRIEF.md
# Write-Through Byte Cache

This block is a tiny fully associative data cache placed between a byte-wide load/store port and a byte-wide memory port. Every store goes to memory right away, whether it hits or misses. A store miss first brings the whole block into the cache. Lines never hold data that is newer than memory, so replacing a line never costs a memory write.

A request is taken when the cache reports it is idle. The access ends with a one-cycle done pulse, and a load returns its byte on the read-data output. A miss reads the whole block from memory, one byte per handshake, and then finishes like a hit. Two free-running counters record how many accesses hit and how many missed.

Top module: `wtc_cache`

## Requirements
- R1: An address is five bits. Bits [4:1] are the block tag and bit 0 selects the byte within the block. A load returns the byte at that exact address.
- R2: Two lines are held, and any block may occupy either line. A second access to a block that is still resident is a hit and causes no memory read.
- R3: A miss, load or store, reads the whole block with exactly two memory reads: offset 0 first, then offset 1.
- R4: Every store causes exactly one memory write, on a hit or on a miss, carrying the store's address and byte.
- R5: A store miss allocates the block. A later load of either byte of that block hits and returns the stored byte or the memory byte.
- R6: Loads never write memory, and evicting a line causes no memory traffic.
- R7: On a miss, an invalid line is filled before any valid line is replaced. Otherwise the least recently used line is replaced, and every hit or fill makes its line the most recent.
- R8: `cpu_done` is high for exactly one cycle per access. `cpu_ready` is high only while idle, and no memory request is made while idle.
- R9: Each access adds one to exactly one of `hit_cnt` and `miss_cnt`. Reset clears both counters and invalidates every line.
- R10: Once `mem_req` is raised, it stays high with a stable address, direction and write byte until a cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 5 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Idle, can take a request |
| cpu_done | output | 1 | One-cycle pulse when the access completes |
| cpu_rdata | output | 8 | Load result, valid from the done pulse |
| hit_cnt | output | 16 | Accesses that hit |
| miss_cnt | output | 16 | Accesses that missed |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 5 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in a cycle where `mem_ready` is high |
| mem_ready | input | 1 | Completes the current memory transfer |

## Verification
The assertions assume two things. First, memory only completes a transfer while `mem_req` is high. Second, the requester raises `cpu_req` only while `cpu_ready` is high and waits for the done pulse before the next request. The stimulus always does this, because each access is issued from a single task that waits for the done pulse and one further idle cycle. Memory readiness follows a repeating pattern with a stall cycle, so the hold rule on the memory port is exercised on every kind of transfer. The bench runs the given load/store sequence, every address, every ordered pair of blocks with a return access, and a pseudo-random mix, all against an arithmetic model of tags, recency and memory contents.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_FILL,
      ST_PUT,
      ST_DONE
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
   parameter int LINES = 2,
   parameter int TAG_W = 4,
   parameter int IDX_W = 1
) (
   input  logic [LINES-1:0]            vld,
   input  logic [LINES-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]            probe,
   output logic                        hit,
   output logic [IDX_W-1:0]            hit_idx
);
   logic [LINES-1:0] match;

   for (genvar g = 0; g < LINES; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == probe);
   end

   assign hit = |match;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < LINES; i++) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
   parameter int LINES = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [LINES-1:0] vld,
   output logic [IDX_W-1:0] victim
);
   logic             any_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] old_idx;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign victim = any_free ? free_idx : old_idx;

   if (LINES == 2) begin : g_pair
      logic lru_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lru_q <= 1'b0;
         else if (touch)  lru_q <= ~touch_idx[0];
      end
      assign old_idx = lru_q;
   end else begin : g_ages
      logic [LINES-1:0][IDX_W-1:0] age_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int j = 0; j < LINES; j++) age_q[j] <= IDX_W'(j);
         end else if (touch) begin
            for (int j = 0; j < LINES; j++) begin
               if (IDX_W'(j) == touch_idx)          age_q[j] <= '0;
               else if (age_q[j] < age_q[touch_idx]) age_q[j] <= age_q[j] + 1'b1;
            end
         end
      end
      always_comb begin
         old_idx = '0;
         for (int j = 0; j < LINES; j++) begin
            if (age_q[j] == IDX_W'(LINES - 1)) old_idx = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
   parameter int ADDR_W = 5,
   parameter int OFF_W  = 1,
   parameter int LINES  = 2,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [CNT_W-1:0]  hit_cnt,
   output logic [CNT_W-1:0]  miss_cnt,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   import wtc_pkg::*;

   localparam int TAG_W = ADDR_W - OFF_W;
   localparam int BYTES = 1 << OFF_W;
   localparam int IDX_W = $clog2(LINES);

   if (OFF_W < 1 || OFF_W >= ADDR_W) begin : g_bad_off
      $error("wtc_cache: OFF_W must lie in 1..ADDR_W-1");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("wtc_cache: LINES must be a power of two, at least 2");
   end

   wtc_state_e state_q;
   logic                          we_q;
   logic [TAG_W-1:0]              tag_q;
   logic [OFF_W-1:0]              off_q;
   logic [DATA_W-1:0]             wdat_q;
   logic                          refill_q;
   logic [IDX_W-1:0]              vict_q;
   logic [OFF_W-1:0]              fill_q;
   logic [LINES-1:0]              vld_q;
   logic [LINES-1:0][TAG_W-1:0]   tag_arr;
   logic [LINES-1:0][BYTES-1:0][DATA_W-1:0] dat_arr;

   logic             hit;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] victim;
   logic             lru_touch;

   wtc_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
      .vld     (vld_q),
      .tags    (tag_arr),
      .probe   (tag_q),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

   assign lru_touch = (state_q == ST_LOOK) && hit;

   wtc_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (lru_touch),
      .touch_idx (hit_idx),
      .vld       (vld_q),
      .victim    (victim)
   );

   assign cpu_ready = (state_q == ST_IDLE);
   assign cpu_done  = (state_q == ST_DONE);
   assign mem_req   = (state_q == ST_FILL) || (state_q == ST_PUT);
   assign mem_we    = (state_q == ST_PUT);
   assign mem_addr  = (state_q == ST_FILL) ? {tag_q, fill_q} : {tag_q, off_q};
   assign mem_wdata = wdat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         we_q      <= 1'b0;
         tag_q     <= '0;
         off_q     <= '0;
         wdat_q    <= '0;
         refill_q  <= 1'b0;
         vict_q    <= '0;
         fill_q    <= '0;
         vld_q     <= '0;
         tag_arr   <= '0;
         dat_arr   <= '0;
         cpu_rdata <= '0;
         hit_cnt   <= '0;
         miss_cnt  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  we_q    <= cpu_we;
                  tag_q   <= cpu_addr[ADDR_W-1:OFF_W];
                  off_q   <= cpu_addr[OFF_W-1:0];
                  wdat_q  <= cpu_wdata;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (hit) begin
                  refill_q <= 1'b0;
                  if (!refill_q) hit_cnt <= hit_cnt + 1'b1;
                  if (we_q) begin
                     dat_arr[hit_idx][off_q] <= wdat_q;
                     state_q <= ST_PUT;
                  end else begin
                     cpu_rdata <= dat_arr[hit_idx][off_q];
                     state_q   <= ST_DONE;
                  end
               end else begin
                  miss_cnt        <= miss_cnt + 1'b1;
                  vict_q          <= victim;
                  vld_q[victim]   <= 1'b0;
                  tag_arr[victim] <= tag_q;
                  fill_q          <= '0;
                  state_q         <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ready) begin
                  dat_arr[vict_q][fill_q] <= mem_rdata;
                  fill_q <= fill_q + 1'b1;
                  if (fill_q == OFF_W'(BYTES - 1)) begin
                     vld_q[vict_q] <= 1'b1;
                     refill_q      <= 1'b1;
                     state_q       <= ST_LOOK;
                  end
               end
            end
            ST_PUT: begin
               if (mem_ready) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int BYTES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              cpu_done,
   input logic [CNT_W-1:0]  hit_cnt,
   input logic [CNT_W-1:0]  miss_cnt,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready
);
   logic [7:0] wr_seen;
   logic [7:0] rd_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_seen <= '0;
         rd_seen <= '0;
      end else if (cpu_done) begin
         wr_seen <= '0;
         rd_seen <= '0;
      end else if (mem_req && mem_ready) begin
         if (mem_we) wr_seen <= wr_seen + 1'b1;
         else        rd_seen <= rd_seen + 1'b1;
      end
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R9
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({hit_cnt != $past(hit_cnt), miss_cnt != $past(miss_cnt)}) <= 1)
      && (hit_cnt == $past(hit_cnt) || hit_cnt == $past(hit_cnt) + 1'b1)
      && (miss_cnt == $past(miss_cnt) || miss_cnt == $past(miss_cnt) + 1'b1));

   // R4
   one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> (wr_seen <= 8'd1));

   // R3
   fill_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> (rd_seen == 8'd0 || rd_seen == 8'(BYTES)));
endmodule

bind wtc_cache wtc_cache_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .BYTES  (1 << OFF_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready),
   .cpu_done  (cpu_done),
   .hit_cnt   (hit_cnt),
   .miss_cnt  (miss_cnt),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready)
);

// File: tb/test_wtc_cache.sv
module test_wtc_cache;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 1'b0;
   logic       cpu_we = 1'b0;
   logic [4:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic       cpu_ready, cpu_done;
   logic [7:0] cpu_rdata;
   logic [15:0] hit_cnt, miss_cnt;
   logic       mem_req, mem_we;
   logic [4:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic       mem_ready;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wtc_cache i_wtc_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // memory model
   function automatic logic [7:0] init_byte(input int a);
      return 8'(a * 29 + 7);
   endfunction

   logic [31:0] wr_valid = '0;
   logic [7:0]  wr_mem [32];
   logic [1:0]  tick = '0;
   int          rd_tot = 0, wr_tot = 0, hs_err = 0;
   logic [4:0]  rd_last = '0, rd_prev = '0, last_wa = '0;
   logic [7:0]  last_wd = '0;
   logic        p_req = 1'b0, p_rdy = 1'b0;
   logic [4:0]  p_addr = '0;

   function automatic logic [7:0] mem_view(input logic [4:0] a);
      return wr_valid[a] ? wr_mem[a] : init_byte(int'(a));
   endfunction

   assign mem_ready = (tick != 2'd1);
   assign mem_rdata = mem_view(mem_addr);

   always @(posedge clk) begin
      tick <= tick + 2'd1;
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            wr_mem[mem_addr]   <= mem_wdata;
            wr_valid[mem_addr] <= 1'b1;
            wr_tot  <= wr_tot + 1;
            last_wa <= mem_addr;
            last_wd <= mem_wdata;
         end else begin
            rd_tot  <= rd_tot + 1;
            rd_prev <= rd_last;
            rd_last <= mem_addr;
         end
      end
      if (p_req && !p_rdy && (!mem_req || mem_addr != p_addr)) hs_err <= hs_err + 1;
      p_req  <= mem_req;
      p_rdy  <= mem_ready;
      p_addr <= mem_addr;
   end

   // reference model
   bit         rv [2];
   logic [3:0] rt [2];
   int         rlru;
   logic [7:0] rmem [32];
   int         exp_hit = 0, exp_miss = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      rv[0] = 0; rv[1] = 0; rlru = 0; exp_hit = 0; exp_miss = 0;
   endtask

   task automatic model(input bit we, input logic [4:0] a, input logic [7:0] d, output bit h);
      int idx;
      idx = -1;
      for (int i = 0; i < 2; i++) if (rv[i] && rt[i] == a[4:1]) idx = i;
      h = (idx >= 0);
      if (!h) begin
         if (!rv[0])      idx = 0;
         else if (!rv[1]) idx = 1;
         else             idx = rlru;
         rv[idx] = 1;
         rt[idx] = a[4:1];
         exp_miss++;
      end else begin
         exp_hit++;
      end
      rlru = 1 - idx;
      if (we) rmem[a] = d;
   endtask

   task automatic access(input bit we, input logic [4:0] a, input logic [7:0] d, input string tag);
      int  rd0, wr0, guard;
      bit  h;
      logic [7:0] expect_rd;
      rd0 = rd_tot; wr0 = wr_tot;
      expect_rd = rmem[a];
      model(we, a, d, h);
      @(negedge clk);
      chk("R8 ready before request", 32'(cpu_ready), 32'd1);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0;
      guard = 0;
      while (!cpu_done && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      chk("R8 done reached", 32'(cpu_done), 32'd1);
      if (!we) chk("R1 load byte", 32'(cpu_rdata), 32'(expect_rd));
      chk({tag, " hit count"}, 32'(hit_cnt), 32'(exp_hit));
      chk({tag, " miss count"}, 32'(miss_cnt), 32'(exp_miss));
      chk("R3 block reads", 32'(rd_tot - rd0), h ? 32'd0 : 32'd2);
      if (!h) begin
         chk("R3 read order low", 32'(rd_prev), 32'({a[4:1], 1'b0}));
         chk("R3 read order high", 32'(rd_last), 32'({a[4:1], 1'b1}));
      end
      if (we) begin
         chk("R4 one write", 32'(wr_tot - wr0), 32'd1);
         chk("R4 write addr", 32'(last_wa), 32'(a));
         chk("R4 write byte", 32'(last_wd), 32'(d));
      end else begin
         chk("R6 no write", 32'(wr_tot - wr0), 32'd0);
      end
      @(negedge clk);
      chk("R8 single done", 32'(cpu_done), 32'd0);
      chk("R8 idle again", 32'(cpu_ready), 32'd1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 reset hit count", 32'(hit_cnt), 32'd0);
      chk("R9 reset miss count", 32'(miss_cnt), 32'd0);
      chk("R8 reset idle", 32'(cpu_ready), 32'd1);
      chk("R8 reset no mem req", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < 32; i++) rmem[i] = init_byte(i);
      model_reset();
      do_reset();

      // given load/store sequence
      access(0, 5'd1,  8'h00, "R2");
      access(0, 5'd7,  8'h00, "R2");
      access(1, 5'd0,  8'h3C, "R2");
      access(1, 5'd5,  8'h5A, "R5");
      access(0, 5'd10, 8'h00, "R7");
      access(1, 5'd5,  8'h81, "R5");
      access(1, 5'd10, 8'h92, "R5");
      access(1, 5'd5,  8'h17, "R2");
      access(1, 5'd10, 8'h28, "R2");
      access(0, 5'd11, 8'h00, "R5");
      access(0, 5'd4,  8'h00, "R5");

      // recency order: A B A C A B C
      access(0, 5'd2,  8'h00, "R7");
      access(0, 5'd20, 8'h00, "R7");
      access(0, 5'd3,  8'h00, "R7");
      access(0, 5'd30, 8'h00, "R7");
      access(0, 5'd2,  8'h00, "R7");
      access(0, 5'd21, 8'h00, "R7");
      access(0, 5'd31, 8'h00, "R7");

      // reset invalidates lines
      do_reset();
      access(0, 5'd2,  8'h00, "R9");
      access(0, 5'd3,  8'h00, "R2");

      // every address: load then store
      for (int a = 0; a < 32; a++) access(0, 5'(a), 8'h00, "R1");
      for (int a = 0; a < 32; a++) access(1, 5'(a), 8'(a * 7 + 1), "R5");
      for (int a = 0; a < 32; a++) access(0, 5'(a ^ 1), 8'h00, "R5");

      // every ordered pair of blocks, then return to the first
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            access(0, 5'({4'(x), 1'b0}), 8'h00, "R7");
            access(1, 5'({4'(y), 1'b1}), 8'(x + y * 16), "R7");
            access(0, 5'({4'(x), 1'b1}), 8'h00, "R7");
         end
      end

      // pseudo-random mix
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         access(lfsr[9], lfsr[4:0], lfsr[15:8], "R7");
      end

      // memory image matches the model
      for (int a = 0; a < 32; a++) chk("R4 memory image", 32'(mem_view(5'(a))), 32'(rmem[a]));
      chk("R10 memory hold", 32'(hs_err), 32'd0);

      finish_run();
   end
endmodule